// File: doc/BRIEF.md
# Program-Order Writeback Scheduler

This block schedules register-file writeback for a simple in-order-issue pipeline whose functional units have different fixed latencies. The table is indexed by the number of cycles left before an entry is written back. An issuing instruction supplies its latency, destination register tag and program-order sequence number. When the issue is accepted, the entry is placed in the row that matches its latency. On every clock edge the whole table advances one row toward row 0. Row 0 drives the writeback port.

Results must leave in program order so that an exception always has a clean boundary. To guarantee this, the block refuses any issue that would finish at or before an entry already in flight. A newer short operation therefore waits behind an older long one, even when the two share no data. The ready signal is evaluated against the table as it will look after the current shift. An entry that is leaving row 0 in this cycle therefore never blocks anything.

An exception flush discards every entry in flight and suppresses the writeback of the current cycle.

Top module: `result_shift_table`

## Requirements
- R1: After synchronous reset the table is empty: wb_valid is low, and issue_ready is high for any in-range latency while flush is low.
- R2: An issue accepted in cycle c with latency L (1 to DEPTH-1) is presented in cycle c+L+1 with wb_valid high, carrying the issued tag on wb_dest_tag and the issued sequence number on wb_seq.
- R3: wb_valid is low in every cycle in which no accepted entry is due.
- R4: issue_ready is low when any entry still in flight would be written back in cycle c+L+1 or later, where c is the current cycle and L is the offered latency. The destination tags play no part in this decision.
- R5: issue_latency is LAT_W = clog2(DEPTH)+1 bits wide. A value of 0, or a value of DEPTH or more, holds issue_ready low, and an issue offered with such a value never produces a writeback.
- R6: An entry due in cycle c+L does not block an issue of latency L in cycle c. Two back-to-back issues with the same latency are both accepted.
- R7: When flush is high, wb_valid is low in that cycle, issue_ready is low, and every entry in flight is discarded without being written back.
- R8: Successive writebacks carry strictly increasing wb_seq values whenever the issued sequence numbers increase.
- R9: At most one entry is accepted per cycle, and only when issue_valid and issue_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Exception flush; discards all entries |
| issue_valid | input | 1 | An instruction is offered for issue |
| issue_latency | input | LAT_W | Execution latency of the offered instruction |
| issue_dest_tag | input | TAG_W | Destination register tag |
| issue_seq | input | SEQ_W | Program-order sequence number |
| issue_ready | output | 1 | The offered latency may issue this cycle |
| wb_valid | output | 1 | Writeback port carries a result this cycle |
| wb_dest_tag | output | TAG_W | Register tag to write |
| wb_seq | output | SEQ_W | Sequence number of the written entry |

## Verification
The ordering assertion assumes that the issuer hands out sequence numbers that rise by one per accepted instruction and never wrap between resets. The bench keeps to this by incrementing its counter only on acceptance and running far fewer issues than the 16-bit range allows. The latency-one assertion assumes that issue_seq is stable only within the cycle in which the issue is sampled, which a clocked issuer provides. The stimulus mixes directed sequences with a long randomized run. That run offers latencies both inside and outside the legal range and raises flush at a low rate, including in cycles where a writeback is due.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

    parameter int unsigned TAG_W = 5;
    parameter int unsigned SEQ_W = 16;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [SEQ_W-1:0] seq;
    } slot_t;

    function automatic slot_t empty_slot();
        slot_t s;
        s.valid = 1'b0;
        s.tag   = '0;
        s.seq   = '0;
        return s;
    endfunction

    function automatic logic lat_legal(input int unsigned lat, input int unsigned depth);
        return (lat >= 1) && (lat < depth);
    endfunction

endpackage

// File: rtl/rsr_row_array.sv
module rsr_row_array
    import rsr_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LAT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             ins_en,
    input  logic [LAT_W-1:0] ins_lat,
    input  slot_t            ins_slot,
    output slot_t            head,
    output logic [DEPTH-1:0] shifted_valid
);

    slot_t rows [DEPTH];
    slot_t shifted [DEPTH];
    slot_t nxt [DEPTH];
    logic [DEPTH-1:0] row_valid;

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_row
            if (i == DEPTH - 1) begin : g_top
                assign shifted[i] = empty_slot();
            end else begin : g_mid
                assign shifted[i] = rows[i+1];
            end

            assign shifted_valid[i] = shifted[i].valid;
            assign row_valid[i]     = rows[i].valid;

            always_comb begin
                if (flush)
                    nxt[i] = empty_slot();
                else if (ins_en && (int'(ins_lat) == i))
                    nxt[i] = ins_slot;
                else
                    nxt[i] = shifted[i];
            end

            always_ff @(posedge clk) begin
                if (rst)
                    rows[i] <= empty_slot();
                else
                    rows[i] <= nxt[i];
            end
        end
    endgenerate

    assign head = rows[0];

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (row_valid == '0));

endmodule

// File: rtl/rsr_order_check.sv
module rsr_order_check
    import rsr_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LAT_W = $clog2(DEPTH) + 1
) (
    input  logic [DEPTH-1:0] shifted_valid,
    input  logic [LAT_W-1:0] lat,
    input  logic             flush,
    output logic             ready
);

    logic [DEPTH-1:0] conflict;

    genvar j;
    generate
        for (j = 0; j < DEPTH; j++) begin : g_cmp
            assign conflict[j] = shifted_valid[j] && (j >= int'(lat));
        end
    endgenerate

    assign ready = lat_legal(int'(lat), DEPTH) && !flush && (conflict == '0);

endmodule

// File: rtl/result_shift_table.sv
module result_shift_table
    import rsr_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned LAT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             issue_valid,
    input  logic [LAT_W-1:0] issue_latency,
    input  logic [TAG_W-1:0] issue_dest_tag,
    input  logic [SEQ_W-1:0] issue_seq,
    output logic             issue_ready,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_dest_tag,
    output logic [SEQ_W-1:0] wb_seq
);

    slot_t            head;
    slot_t            new_slot;
    logic [DEPTH-1:0] shifted_valid;
    logic             accept;

    assign accept         = issue_valid && issue_ready;
    assign new_slot.valid = 1'b1;
    assign new_slot.tag   = issue_dest_tag;
    assign new_slot.seq   = issue_seq;

    rsr_order_check #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_order (
        .shifted_valid (shifted_valid),
        .lat           (issue_latency),
        .flush         (flush),
        .ready         (issue_ready)
    );

    rsr_row_array #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_rows (
        .clk           (clk),
        .rst           (rst),
        .flush         (flush),
        .ins_en        (accept),
        .ins_lat       (issue_latency),
        .ins_slot      (new_slot),
        .head          (head),
        .shifted_valid (shifted_valid)
    );

    assign wb_valid    = head.valid && !flush;
    assign wb_dest_tag = head.tag;
    assign wb_seq      = head.seq;

    // Ordering monitor state for the checks below
    logic [SEQ_W-1:0] last_wb_seq;
    logic             seen_wb;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_wb_seq <= '0;
            seen_wb     <= 1'b0;
        end else if (wb_valid) begin
            last_wb_seq <= wb_seq;
            seen_wb     <= 1'b1;
        end
    end

    // R8
    wb_order_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && seen_wb) |-> (wb_seq > last_wb_seq));

    // R5
    lat_range_stall_chk: assert property (@(posedge clk) disable iff (rst)
        ((issue_latency == '0) || (int'(issue_latency) >= DEPTH)) |-> !issue_ready);

    // R2
    lat1_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (issue_latency == LAT_W'(1))) ##1 !flush ##1 !flush
        |-> (wb_valid && (wb_seq == $past(issue_seq, 2))));

endmodule

// File: tb/result_shift_table_tb_top.sv
module result_shift_table_tb_top;

    localparam int DEPTH = 8;
    localparam int LAT_W = $clog2(DEPTH) + 1;
    localparam int TAG_W = 5;
    localparam int SEQ_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic issue_valid = 1'b0;
    logic [LAT_W-1:0] issue_latency = '0;
    logic [TAG_W-1:0] issue_dest_tag = '0;
    logic [SEQ_W-1:0] issue_seq = '0;
    logic issue_ready;
    logic wb_valid;
    logic [TAG_W-1:0] wb_dest_tag;
    logic [SEQ_W-1:0] wb_seq;

    always #10 clk = ~clk;

    result_shift_table #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .issue_valid(issue_valid), .issue_latency(issue_latency),
        .issue_dest_tag(issue_dest_tag), .issue_seq(issue_seq),
        .issue_ready(issue_ready), .wb_valid(wb_valid),
        .wb_dest_tag(wb_dest_tag), .wb_seq(wb_seq)
    );

    typedef struct {
        int     tag;
        int     seq;
        longint due;
    } pend_t;

    pend_t  q[$];
    int     vecs = 0;
    int     errs = 0;
    longint cyc = 0;
    int     next_seq = 1;
    int     last_seq = 0;
    bit     done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock of stimulus followed by a comparison against the reference model
    task automatic step(input bit v, input int lat, input int tag, input bit fl);
        int    hit;
        bit    exp_wb;
        bit    exp_rdy;
        bit    legal;
        string lbl;
        @(posedge clk);
        #2;
        issue_valid    = v;
        issue_latency  = LAT_W'(lat);
        issue_dest_tag = TAG_W'(tag);
        issue_seq      = SEQ_W'(next_seq);
        flush          = fl;
        @(negedge clk);
        cyc++;
        hit = -1;
        foreach (q[k]) if (q[k].due == cyc) hit = k;
        exp_wb = (hit >= 0) && !fl;
        lbl = (hit >= 0) ? (fl ? "R7" : "R2") : "R3";
        chk(wb_valid == exp_wb, lbl, "wb_valid", int'(wb_valid), int'(exp_wb));
        if (exp_wb && wb_valid) begin
            chk(int'(wb_dest_tag) == q[hit].tag, "R2", "wb_dest_tag", int'(wb_dest_tag), q[hit].tag);
            chk(int'(wb_seq) == q[hit].seq, "R2", "wb_seq", int'(wb_seq), q[hit].seq);
            chk(int'(wb_seq) > last_seq, "R8", "wb_seq order", int'(wb_seq), last_seq + 1);
            last_seq = int'(wb_seq);
        end
        legal = (lat >= 1) && (lat < DEPTH);
        exp_rdy = legal && !fl;
        foreach (q[k]) if (q[k].due > cyc + lat) exp_rdy = 0;
        lbl = !legal ? "R5" : (fl ? "R7" : "R4");
        chk(issue_ready == exp_rdy, lbl, "issue_ready", int'(issue_ready), int'(exp_rdy));
        if (hit >= 0) q.delete(hit);
        if (fl) begin
            q.delete();
        end else if (v && exp_rdy) begin
            // R9: one entry per accepted cycle
            q.push_back('{tag: tag, seq: next_seq, due: cyc + lat + 1});
            next_seq++;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        issue_latency = LAT_W'(3);
        @(negedge clk);
        cyc++;
        chk(wb_valid == 1'b0, "R1", "wb_valid after reset", int'(wb_valid), 0);
        chk(issue_ready == 1'b1, "R1", "issue_ready after reset", int'(issue_ready), 1);

        // R2: single issues of several latencies
        step(1, 1, 3, 0);  idle(3);
        step(1, 7, 9, 0);  idle(9);
        // R4: newer short instruction waits behind older long one (different tags)
        step(1, 6, 1, 0);
        step(1, 2, 2, 0);
        step(1, 2, 2, 0);
        step(1, 2, 2, 0);
        idle(8);
        // R6: equal latency back to back
        step(1, 3, 4, 0);
        step(1, 3, 5, 0);
        step(1, 3, 6, 0);
        idle(6);
        // R5: illegal latencies
        step(1, 0, 7, 0);
        step(1, 8, 7, 0);
        step(1, 15, 7, 0);
        idle(10);
        // R7: flush while entries are in flight and one is due
        step(1, 2, 10, 0);
        step(1, 4, 11, 0);
        step(0, 1, 0, 0);
        step(1, 5, 12, 1);
        idle(8);
        // R9: valid low never inserts
        step(0, 2, 13, 0);
        idle(4);
        // Randomized phases with varying density and flush rate
        for (int ph = 0; ph < 4; ph++) begin
            for (int n = 0; n < 2500; n++) begin
                step(($urandom_range(0, 3) <= ph) ? 1'b1 : 1'b0,
                     int'($urandom_range(0, 9)),
                     int'($urandom_range(0, 31)),
                     ($urandom_range(0, 99) < 2) ? 1'b1 : 1'b0);
            end
            idle(10);
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule